// File: doc/BRIEF.md
# Clocked-Select Dual 4:1 Multiplexer with Output Hold

This block is one control bank feeding two independent 4:1 data multiplexers. Each channel picks one of four input ports (A, B, C or D) and drives it onto its own output. Both channels share a clock, an active-low clock enable and a mode pin. Each channel has its own 2-bit select and its own active-low output enable. Data moves one way only, from the four input ports to the output.

With the mode pin low, the selects are captured in a per-channel select register on a clock edge, but only while the clock enable is asserted. With the mode pin high, the select pins steer the channel directly and the clock enable has no effect. The output enable overrides everything. While a channel's switch is off, a last-value register drives its output, so the output never floats. Every change of the connected port opens the switch for one clock cycle before the new port is connected. The previous port is therefore released before the next one is joined.

Top module: `synq_mux_bank`

## Requirements
- R1: The select code uses select bit 0 as its LSB. Code 0 connects port A, code 1 port B, code 2 port C and code 3 port D.
- R2: With `direct_sel` low and `clk_en_n` low, a rising clock edge stores the select pins in the channel's select register. The channel then connects the stored port after the break cycle of R7.
- R3: With `direct_sel` low and `clk_en_n` high, the select register keeps its contents across clock edges. The connected channel's output follows the live data of its port in the same cycle, with no register delay.
- R4: With `direct_sel` high, the select pins choose the port directly. Neither the clock nor `clk_en_n` loads the select register; the stored value is intact when the mode pin returns low.
- R5: A channel whose `oe_n` bit is high has its switch off in both modes. Its output shows the last value it drove, whatever the selects, data and clock enable do.
- R6: In clocked mode the select register still loads while the channel's `oe_n` is high. When `oe_n` drops, the channel connects to the port stored during the disabled time.
- R7: When the effective select differs from the port connected at the last clock edge, the switch stays off for one cycle and the output holds. No such gap occurs when a load stores the port that is already connected.
- R8: On each clock edge where the switch is on, the hold register captures the output value. That value is what the output shows whenever the switch is off.
- R9: A synchronous active-high `rst` sets each select register and connected port to port A and clears each hold register to zero.
- R10: The two channels act independently in select, enable, break cycle and held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both channels |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low enable for loading the select registers |
| direct_sel | input | 1 | High: selects act directly; low: selects pass through the register |
| sel | input | 2*NUM_CH | Per-channel 2-bit select, channel c at bits [2c+1:2c] |
| oe_n | input | NUM_CH | Per-channel active-low output enable |
| port_a | input | NUM_CH*DATA_W | Port A data, channel c at bits [c*DATA_W +: DATA_W] |
| port_b | input | NUM_CH*DATA_W | Port B data, same packing |
| port_c | input | NUM_CH*DATA_W | Port C data, same packing |
| port_d | input | NUM_CH*DATA_W | Port D data, same packing |
| y_out | output | NUM_CH*DATA_W | Channel outputs, same packing |

## Verification
A connected output is combinational from the data ports, so a data change shows at `y_out` in the same cycle. A select stored at an edge, or a direct select pin that changes, gives one held cycle and the new port appears after the following edge. An `oe_n` change takes effect at once. The bench drives every input on the falling edge and samples one nanosecond later, before the next rising edge. Its reference model advances the stored select, the connected port and the held value only at the rising edges. Each expected value therefore reflects exactly the edges that have passed.

// File: rtl/synq_mux_pkg.sv
package synq_mux_pkg;

    typedef enum logic [1:0] {
        SRC_A = 2'd0,
        SRC_B = 2'd1,
        SRC_C = 2'd2,
        SRC_D = 2'd3
    } src_e;

    typedef struct packed {
        logic direct;
        logic load_n;
        logic oe_n;
        src_e pins;
    } ch_ctrl_t;

    typedef struct packed {
        src_e stored;
        src_e eff;
        src_e conn;
        logic on;
    } ch_state_t;

    function automatic src_e code_to_src(input logic [1:0] code);
        src_e s;
        case (code)
            2'd0:    s = SRC_A;
            2'd1:    s = SRC_B;
            2'd2:    s = SRC_C;
            default: s = SRC_D;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/synq_sel_ctrl.sv
module synq_sel_ctrl
    import synq_mux_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ch_ctrl_t  ctrl,
    output ch_state_t state
);

    src_e stored_q;
    src_e conn_q;
    src_e eff;
    logic load_now;

    assign load_now = !ctrl.direct && !ctrl.load_n;

    // Stored select: only clocked mode with enable asserted writes it.
    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= SRC_A;
        end else if (load_now) begin
            stored_q <= ctrl.pins;
        end
    end

    assign eff = ctrl.direct ? ctrl.pins : stored_q;

    // Port connected at the last edge; a mismatch opens the switch.
    always_ff @(posedge clk) begin
        if (rst) begin
            conn_q <= SRC_A;
        end else begin
            conn_q <= eff;
        end
    end

    always_comb begin
        state.stored = stored_q;
        state.eff    = eff;
        state.conn   = conn_q;
        state.on     = !ctrl.oe_n && (eff == conn_q);
    end

endmodule

// File: rtl/synq_port_mux.sv
module synq_port_mux
    import synq_mux_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_c,
    input  logic [DATA_W-1:0] in_d,
    input  src_e              pick,
    output logic [DATA_W-1:0] live
);

    always_comb begin
        live = in_a;
        case (pick)
            SRC_A: live = in_a;
            SRC_B: live = in_b;
            SRC_C: live = in_c;
            SRC_D: live = in_d;
            default: live = in_a;
        endcase
    end

endmodule

// File: rtl/synq_hold_out.sv
module synq_hold_out #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_on,
    input  logic [DATA_W-1:0] live,
    output logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] held
);

    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (sw_on) begin
            held_q <= live;
        end
    end

    assign y    = sw_on ? live : held_q;
    assign held = held_q;

endmodule

// File: rtl/synq_mux_bank.sv
module synq_mux_bank
    import synq_mux_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clk_en_n,
    input  logic                     direct_sel,
    input  logic [2*NUM_CH-1:0]      sel,
    input  logic [NUM_CH-1:0]        oe_n,
    input  logic [NUM_CH*DATA_W-1:0] port_a,
    input  logic [NUM_CH*DATA_W-1:0] port_b,
    input  logic [NUM_CH*DATA_W-1:0] port_c,
    input  logic [NUM_CH*DATA_W-1:0] port_d,
    output logic [NUM_CH*DATA_W-1:0] y_out
);

    localparam int SEL_W = 2 * NUM_CH;
    localparam int BUS_W = NUM_CH * DATA_W;

    logic [SEL_W-1:0]  stored_v;
    logic [SEL_W-1:0]  eff_v;
    logic [SEL_W-1:0]  conn_v;
    logic [NUM_CH-1:0] on_v;
    logic [BUS_W-1:0]  held_v;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_ctrl_t          ctrl;
        ch_state_t         st;
        logic [DATA_W-1:0] live;

        always_comb begin
            ctrl.direct = direct_sel;
            ctrl.load_n = clk_en_n;
            ctrl.oe_n   = oe_n[c];
            ctrl.pins   = code_to_src(sel[2*c +: 2]);
        end

        synq_sel_ctrl u_sel (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (ctrl),
            .state (st)
        );

        synq_port_mux #(.DATA_W(DATA_W)) u_mux (
            .in_a (port_a[c*DATA_W +: DATA_W]),
            .in_b (port_b[c*DATA_W +: DATA_W]),
            .in_c (port_c[c*DATA_W +: DATA_W]),
            .in_d (port_d[c*DATA_W +: DATA_W]),
            .pick (st.eff),
            .live (live)
        );

        synq_hold_out #(.DATA_W(DATA_W)) u_hold (
            .clk   (clk),
            .rst   (rst),
            .sw_on (st.on),
            .live  (live),
            .y     (y_out[c*DATA_W +: DATA_W]),
            .held  (held_v[c*DATA_W +: DATA_W])
        );

        assign stored_v[2*c +: 2] = st.stored;
        assign eff_v[2*c +: 2]    = st.eff;
        assign conn_v[2*c +: 2]   = st.conn;
        assign on_v[c]            = st.on;
    end

endmodule

// File: rtl/synq_mux_bank_chk.sv
module synq_mux_bank_chk #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     clk_en_n,
    input logic                     direct_sel,
    input logic [2*NUM_CH-1:0]      sel,
    input logic [NUM_CH-1:0]        oe_n,
    input logic [NUM_CH*DATA_W-1:0] y_out,
    input logic [2*NUM_CH-1:0]      stored_v,
    input logic [2*NUM_CH-1:0]      eff_v,
    input logic [2*NUM_CH-1:0]      conn_v,
    input logic [NUM_CH-1:0]        on_v,
    input logic [NUM_CH*DATA_W-1:0] held_v
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R2: clocked mode with enable stores the pins
        p_load_r2: assert property (@(posedge clk) disable iff (rst)
            (!direct_sel && !clk_en_n) |=> (stored_v[2*c +: 2] == $past(sel[2*c +: 2])));

        // R3: enable deasserted keeps the stored select
        p_keep_r3: assert property (@(posedge clk) disable iff (rst)
            (!direct_sel && clk_en_n) |=> $stable(stored_v[2*c +: 2]));

        // R4: direct mode never writes the register
        p_direct_r4: assert property (@(posedge clk) disable iff (rst)
            direct_sel |=> $stable(stored_v[2*c +: 2]));

        // R5: output frozen across an edge while disabled
        p_off_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (oe_n[c] && $past(oe_n[c]) && !$past(rst))
            |-> $stable(y_out[c*DATA_W +: DATA_W]));

        // R7: connected port cannot change while switch stays on
        p_bbm_r7: assert property (@(posedge clk) disable iff (rst)
            (on_v[c] && $past(on_v[c]) && !$past(rst))
            |-> (eff_v[2*c +: 2] == $past(eff_v[2*c +: 2])));

        // R8: on switch-off the output keeps the last driven value
        p_capture_r8: assert property (@(posedge clk) disable iff (rst)
            (!on_v[c] && $past(on_v[c]) && !$past(rst))
            |-> (y_out[c*DATA_W +: DATA_W] == $past(y_out[c*DATA_W +: DATA_W])));

        // R9: reset leaves port A stored and connected, hold cleared
        p_reset_r9: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (stored_v[2*c +: 2] == 2'd0 && conn_v[2*c +: 2] == 2'd0
                            && held_v[c*DATA_W +: DATA_W] == '0));
    end

endmodule

bind synq_mux_bank synq_mux_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_en_n   (clk_en_n),
    .direct_sel (direct_sel),
    .sel        (sel),
    .oe_n       (oe_n),
    .y_out      (y_out),
    .stored_v   (stored_v),
    .eff_v      (eff_v),
    .conn_v     (conn_v),
    .on_v       (on_v),
    .held_v     (held_v)
);

// File: tb/synq_mux_bank_bench.sv
module synq_mux_bank_bench;

    localparam int NUM_CH = 2;
    localparam int DATA_W = 8;
    localparam int NROWS  = 15;
    localparam logic [2:0] HLD = 3'd4;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     clk_en_n = 1'b1;
    logic                     direct_sel = 1'b0;
    logic [2*NUM_CH-1:0]      sel = '0;
    logic [NUM_CH-1:0]        oe_n = '0;
    logic [NUM_CH*DATA_W-1:0] port_a, port_b, port_c, port_d;
    logic [NUM_CH*DATA_W-1:0] y_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [DATA_W-1:0] hold_exp [NUM_CH];

    always #2 clk = ~clk;

    synq_mux_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_synq_mux_bank (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .direct_sel(direct_sel),
        .sel(sel), .oe_n(oe_n), .port_a(port_a), .port_b(port_b),
        .port_c(port_c), .port_d(port_d), .y_out(y_out)
    );

    // expected source per channel: 0..3 = port A..D, 4 = held value
    typedef struct packed {
        logic       direct;
        logic       cen_n;
        logic [1:0] s0;
        logic       o0;
        logic [1:0] s1;
        logic       o1;
        logic [2:0] e0;
        logic [2:0] e1;
    } vec_t;

    localparam vec_t TBL [NROWS] = '{
        '{1'b0, 1'b0, 2'd1, 1'b0, 2'd2, 1'b0, 3'd0, 3'd0},
        '{1'b0, 1'b1, 2'd3, 1'b0, 2'd3, 1'b0, HLD,  HLD },
        '{1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 3'd1, 3'd2},
        '{1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 3'd1, 3'd2},
        '{1'b0, 1'b0, 2'd1, 1'b0, 2'd0, 1'b1, 3'd1, HLD },
        '{1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b1, 3'd1, HLD },
        '{1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 3'd1, 3'd0},
        '{1'b1, 1'b0, 2'd2, 1'b0, 2'd3, 1'b0, HLD,  HLD },
        '{1'b1, 1'b0, 2'd2, 1'b0, 2'd3, 1'b0, 3'd2, 3'd3},
        '{1'b1, 1'b0, 2'd3, 1'b1, 2'd3, 1'b0, HLD,  3'd3},
        '{1'b1, 1'b0, 2'd3, 1'b0, 2'd3, 1'b0, 3'd3, 3'd3},
        '{1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, HLD,  HLD },
        '{1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 3'd1, 3'd0},
        '{1'b0, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 3'd1, 3'd0},
        '{1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 3'd1, 3'd0}
    };

    function automatic string row_tag(input int i);
        case (i)
            0:       return "R9";
            1:       return "R7/R8";
            2, 3:    return "R3";
            4, 9:    return "R5";
            5, 6:    return "R6";
            7:       return "R4/R7";
            8, 10:   return "R4";
            11:      return "R4/R7";
            12:      return "R2";
            13:      return "R7";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] dval(input int s, input int c, input int p);
        return DATA_W'((s * 16 + c * 4 + p + 1) % 256);
    endfunction

    task automatic set_data(input int s);
        for (int c = 0; c < NUM_CH; c++) begin
            port_a[c*DATA_W +: DATA_W] = dval(s, c, 0);
            port_b[c*DATA_W +: DATA_W] = dval(s, c, 1);
            port_c[c*DATA_W +: DATA_W] = dval(s, c, 2);
            port_d[c*DATA_W +: DATA_W] = dval(s, c, 3);
        end
    endtask

    task automatic check(input int c, input logic [DATA_W-1:0] exp, input string tag);
        logic [DATA_W-1:0] act;
        act = y_out[c*DATA_W +: DATA_W];
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d: y=%h expected %h at %0t", tag, c, act, exp, $time);
        end
    endtask

    initial begin
        set_data(30);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: after reset the channels connect port A with no gap
        for (int c = 0; c < NUM_CH; c++) begin
            check(c, dval(30, c, 0), "R9");
            hold_exp[c] = dval(30, c, 0);
        end

        // table walk
        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            direct_sel = TBL[i].direct;
            clk_en_n   = TBL[i].cen_n;
            sel        = {TBL[i].s1, TBL[i].s0};
            oe_n       = {TBL[i].o1, TBL[i].o0};
            set_data(i);
            #1;
            for (int c = 0; c < NUM_CH; c++) begin
                logic [2:0] src;
                src = (c == 0) ? TBL[i].e0 : TBL[i].e1;
                if (src == HLD) begin
                    check(c, hold_exp[c], row_tag(i));
                end else begin
                    check(c, dval(i, c, int'(src)), row_tag(i));
                    hold_exp[c] = dval(i, c, int'(src));
                end
            end
        end

        // R9: reset mid-run clears the held values
        @(negedge clk);
        rst = 1'b1;
        clk_en_n = 1'b0;
        sel = 4'b1011;
        @(negedge clk);
        rst = 1'b0;
        clk_en_n = 1'b1;
        oe_n = 2'b11;
        set_data(31);
        #1;
        for (int c = 0; c < NUM_CH; c++) check(c, '0, "R9");
        @(negedge clk);
        oe_n = 2'b00;
        direct_sel = 1'b0;
        set_data(32);
        #1;
        for (int c = 0; c < NUM_CH; c++) check(c, dval(32, c, 0), "R9");

        // R1: every select code in direct mode, after its break cycle
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            direct_sel = 1'b1;
            sel = {2'(3 - k), 2'(k)};
            set_data(40 + k);
            @(negedge clk);
            set_data(50 + k);
            #1;
            check(0, dval(50 + k, 0, k), "R1");
            check(1, dval(50 + k, 1, 3 - k), "R1");
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule